// File: doc/BRIEF.md
# Bit-Sliced Compute-in-Memory Partial-Sum Combiner

This block sits between a compute-in-memory array's readout converters and the rest of a datapath. On a start request it captures one multibit activation per array row. It then presents those activations to the array one narrow input slice at a time, least significant slice first. For every slice the converters return one short code per weight column, for both a positive-weight array and a negative-weight array. Each weight column stores one bit of the weight magnitude.

The block merges these codes without loss. Within a slice, each column code is weighted by the bit position it holds. Across slices, each slice is weighted by its significance: with two 4-bit slices of an 8-bit activation, the upper slice counts sixteen times the lower. The negative-array total is subtracted from the positive-array total, which gives a signed matrix-vector result. That result is held until a downstream consumer takes it.

Each column code has log2(rows) + log2(weight levels) + log2(input-slice levels) + 1 bits, so that one unit input times one unit weight is exactly one code LSB. The accumulator covers the largest shifted sum of all slices plus a sign bit.

Top module: `cim_slice_combiner`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the slice counter and drives `slice_valid`, `res_valid` and `busy` low on the next clock.
- R2: `start` sampled while not busy captures `act_in` and, from the next cycle, raises `busy` and `slice_valid` with `slice_idx` = 0. Row r's activation is `act_in[r*ACT_W +: ACT_W]`. Slice k of row r appears on `slice_data[r*SLICE_W +: SLICE_W]` and equals activation bits `[k*SLICE_W +: SLICE_W]`.
- R3: A slice stays presented, with the same index and data, until `code_valid` is sampled high. The index then steps by one, so the upper slice follows the lower one.
- R4: The code of weight column b, `code_pos[b*CODE_W +: CODE_W]` (and likewise `code_neg`), is weighted by 2^b before the columns are summed.
- R5: The column sum of slice k is weighted by 2^(k*SLICE_W). With the defaults this gives a 16:1 ratio between the upper and lower slice.
- R6: `res_data` is the two's-complement difference of the accumulated positive-array sum minus the accumulated negative-array sum.
- R7: `res_valid` rises in the cycle after the last slice's codes are accepted. It stays high, with `res_data` unchanged, until `res_ready` is sampled high, and then falls.
- R8: `start` while busy, including while a result waits, has no effect on the operation in flight or on the held result.
- R9: All column codes at their maximum value, on either array, give the exact result with no overflow.
- R10: `code_valid` while no slice is presented is ignored. It does not start an operation and does not alter the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation |
| act_in | input | ROWS*ACT_W | Packed per-row activations |
| busy | output | 1 | Operation in flight or result waiting |
| slice_valid | output | 1 | An input slice is being presented to the array |
| slice_idx | output | IDX_W | Index of the presented slice, 0 = least significant |
| slice_data | output | ROWS*SLICE_W | Per-row slice values driven to the array |
| code_valid | input | 1 | Converter codes for the presented slice are valid |
| code_pos | input | WBITS*CODE_W | Positive-array column codes, column b at b*CODE_W |
| code_neg | input | WBITS*CODE_W | Negative-array column codes, column b at b*CODE_W |
| res_valid | output | 1 | Signed result available |
| res_data | output | ACC_W | Signed result, two's complement |
| res_ready | input | 1 | Consumer takes the result |

## Verification
The first slice appears one cycle after `start` is sampled. Each later slice appears one cycle after the codes for the previous slice are sampled. The result appears one cycle after the last slice's codes are sampled. The bench drives every input on the falling edge. It checks each of these outputs at the following falling edge, which lies exactly one register stage after the rising edge that sampled the stimulus. Hold behaviour is checked at several such falling edges in a row, and the checks compare against an integer dot-product model of an ideal array.

// File: rtl/cim_comb_pkg.sv
package cim_comb_pkg;

    localparam int DEF_ROWS    = 2;
    localparam int DEF_ACT_W   = 8;
    localparam int DEF_SLICE_W = 4;
    localparam int DEF_WBITS   = 4;

    // lossless code width: rows, weight levels per column, input levels per slice
    function automatic int code_width(input int rows, input int wlev, input int nlev);
        return $clog2(rows) + $clog2(wlev) + $clog2(nlev) + 1;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic clear;
        logic take;
        logic last;
    } seq_evt_t;

endpackage

// File: rtl/cim_slice_seq.sv
module cim_slice_seq
    import cim_comb_pkg::*;
#(
    parameter int ROWS    = DEF_ROWS,
    parameter int ACT_W   = DEF_ACT_W,
    parameter int SLICE_W = DEF_SLICE_W,
    localparam int NSLICE = ACT_W / SLICE_W,
    localparam int IDX_W  = idx_width(NSLICE)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ROWS*ACT_W-1:0]     act_in,
    input  logic                      code_valid,
    input  logic                      res_ready,
    output logic                      busy,
    output logic                      slice_valid,
    output logic [IDX_W-1:0]          slice_idx,
    output logic [ROWS*SLICE_W-1:0]   slice_data,
    output logic                      res_valid,
    output seq_evt_t                  evt
);

    seq_state_e              state_q;
    logic [IDX_W-1:0]        idx_q;
    logic [ROWS*ACT_W-1:0]   act_q;

    always_comb begin
        evt.clear = (state_q == ST_IDLE) && start;
        evt.take  = (state_q == ST_DRIVE) && code_valid;
        evt.last  = (idx_q == IDX_W'(NSLICE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            act_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_DRIVE;
                        idx_q   <= '0;
                        act_q   <= act_in;
                    end
                end
                ST_DRIVE: begin
                    if (code_valid) begin
                        if (evt.last) state_q <= ST_HOLD;
                        else          idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (res_ready) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign slice_valid = (state_q == ST_DRIVE);
    assign res_valid   = (state_q == ST_HOLD);
    assign slice_idx   = idx_q;

    always_comb begin
        slice_data = '0;
        if (slice_valid) begin
            for (int r = 0; r < ROWS; r++) begin
                slice_data[r*SLICE_W +: SLICE_W] =
                    act_q[r*ACT_W + int'(idx_q)*SLICE_W +: SLICE_W];
            end
        end
    end

endmodule

// File: rtl/cim_col_merge.sv
module cim_col_merge #(
    parameter int CODE_W = 7,
    parameter int NCOL   = 4,
    localparam int OUT_W = CODE_W + NCOL
) (
    input  logic [NCOL*CODE_W-1:0] codes,
    output logic [OUT_W-1:0]       merged
);

    logic [OUT_W-1:0] terms [NCOL];

    for (genvar b = 0; b < NCOL; b++) begin : g_col
        assign terms[b] = OUT_W'(codes[b*CODE_W +: CODE_W]) << b;
    end

    always_comb begin
        merged = '0;
        for (int b = 0; b < NCOL; b++) begin
            merged = merged + terms[b];
        end
    end

endmodule

// File: rtl/cim_acc.sv
module cim_acc #(
    parameter int MRG_W   = 11,
    parameter int ACC_W   = 17,
    parameter int SLICE_W = 4,
    parameter int IDX_W   = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    take,
    input  logic [IDX_W-1:0]        idx,
    input  logic [MRG_W-1:0]        pos_m,
    input  logic [MRG_W-1:0]        neg_m,
    output logic signed [ACC_W-1:0] acc
);

    localparam int EXT_W = ACC_W - MRG_W;

    logic signed [ACC_W-1:0] pos_e, neg_e, diff, term;

    always_comb begin
        pos_e = $signed({{EXT_W{1'b0}}, pos_m});
        neg_e = $signed({{EXT_W{1'b0}}, neg_m});
        diff  = pos_e - neg_e;
        term  = diff <<< (int'(idx) * SLICE_W);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (take)    acc <= acc + term;
    end

endmodule

// File: rtl/cim_slice_combiner.sv
module cim_slice_combiner
    import cim_comb_pkg::*;
#(
    parameter int ROWS    = DEF_ROWS,
    parameter int ACT_W   = DEF_ACT_W,
    parameter int SLICE_W = DEF_SLICE_W,
    parameter int WBITS   = DEF_WBITS,
    localparam int NSLICE = ACT_W / SLICE_W,
    localparam int IDX_W  = idx_width(NSLICE),
    localparam int CODE_W = code_width(ROWS, 2, 2**SLICE_W),
    localparam int MRG_W  = CODE_W + WBITS,
    localparam int ACC_W  = MRG_W + ACT_W - SLICE_W + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ROWS*ACT_W-1:0]     act_in,
    output logic                      busy,
    output logic                      slice_valid,
    output logic [IDX_W-1:0]          slice_idx,
    output logic [ROWS*SLICE_W-1:0]   slice_data,
    input  logic                      code_valid,
    input  logic [WBITS*CODE_W-1:0]   code_pos,
    input  logic [WBITS*CODE_W-1:0]   code_neg,
    output logic                      res_valid,
    output logic signed [ACC_W-1:0]   res_data,
    input  logic                      res_ready
);

    seq_evt_t          evt;
    logic [MRG_W-1:0]  pos_m, neg_m;

    cim_slice_seq #(
        .ROWS(ROWS), .ACT_W(ACT_W), .SLICE_W(SLICE_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .act_in(act_in),
        .code_valid(code_valid), .res_ready(res_ready),
        .busy(busy), .slice_valid(slice_valid), .slice_idx(slice_idx),
        .slice_data(slice_data), .res_valid(res_valid), .evt(evt)
    );

    cim_col_merge #(.CODE_W(CODE_W), .NCOL(WBITS)) u_mrg_pos (
        .codes(code_pos), .merged(pos_m)
    );

    cim_col_merge #(.CODE_W(CODE_W), .NCOL(WBITS)) u_mrg_neg (
        .codes(code_neg), .merged(neg_m)
    );

    cim_acc #(
        .MRG_W(MRG_W), .ACC_W(ACC_W), .SLICE_W(SLICE_W), .IDX_W(IDX_W)
    ) u_acc (
        .clk(clk), .rst(rst), .clear(evt.clear), .take(evt.take),
        .idx(slice_idx), .pos_m(pos_m), .neg_m(neg_m), .acc(res_data)
    );

endmodule

// File: rtl/cim_combiner_chk.sv
module cim_combiner_chk #(
    parameter int IDX_W  = 1,
    parameter int ACC_W  = 17,
    parameter int NSLICE = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    code_valid,
    input logic                    res_ready,
    input logic                    busy,
    input logic                    slice_valid,
    input logic [IDX_W-1:0]        slice_idx,
    input logic                    res_valid,
    input logic signed [ACC_W-1:0] res_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSLICE - 1);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !slice_valid && !res_valid && !busy);

    p_first_slice_r2: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> slice_valid && slice_idx == '0);

    p_slice_step_r3: assert property (@(posedge clk) disable iff (rst)
        slice_valid && code_valid && slice_idx != LAST
        |=> slice_valid && slice_idx == IDX_W'($past(slice_idx) + 1'b1));

    p_slice_wait_r3: assert property (@(posedge clk) disable iff (rst)
        slice_valid && !code_valid |=> slice_valid && $stable(slice_idx));

    p_res_due_r7: assert property (@(posedge clk) disable iff (rst)
        slice_valid && code_valid && slice_idx == LAST |=> res_valid);

    p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_data));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready && start |=> !slice_valid);

    p_stray_code_r10: assert property (@(posedge clk) disable iff (rst)
        !busy && !start && code_valid |=> !busy && !res_valid);

    always @(posedge clk) begin
        if (!rst) begin
            p_excl_r7: assert (!(slice_valid && res_valid));
        end
    end

endmodule

bind cim_slice_combiner cim_combiner_chk #(
    .IDX_W(IDX_W), .ACC_W(ACC_W), .NSLICE(NSLICE)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .code_valid(code_valid),
    .res_ready(res_ready), .busy(busy), .slice_valid(slice_valid),
    .slice_idx(slice_idx), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/sim_cim_slice_combiner.sv
`timescale 1ns/1ps
module sim_cim_slice_combiner;
    import cim_comb_pkg::*;

    localparam int ROWS    = DEF_ROWS;
    localparam int ACT_W   = DEF_ACT_W;
    localparam int SLICE_W = DEF_SLICE_W;
    localparam int WBITS   = DEF_WBITS;
    localparam int IDX_W   = 1;
    localparam int CODE_W  = 7;
    localparam int ACC_W   = 17;
    localparam int CMAX    = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst, start, code_valid, res_ready;
    logic [ROWS*ACT_W-1:0]   act_in;
    logic busy, slice_valid, res_valid;
    logic [IDX_W-1:0]        slice_idx;
    logic [ROWS*SLICE_W-1:0] slice_data;
    logic [WBITS*CODE_W-1:0] code_pos, code_neg;
    logic signed [ACC_W-1:0] res_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cim_slice_combiner u0 (
        .clk(clk), .rst(rst), .start(start), .act_in(act_in), .busy(busy),
        .slice_valid(slice_valid), .slice_idx(slice_idx), .slice_data(slice_data),
        .code_valid(code_valid), .code_pos(code_pos), .code_neg(code_neg),
        .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // ideal array: column b of slice k sums row nibble times weight magnitude bit b
    function automatic logic [WBITS*CODE_W-1:0] model_codes(
        input int a0, input int a1, input int w0, input int w1,
        input int k, input bit neg);
        logic [WBITS*CODE_W-1:0] c = '0;
        int av[2], wv[2];
        av[0] = a0; av[1] = a1; wv[0] = w0; wv[1] = w1;
        for (int b = 0; b < WBITS; b++) begin
            int s = 0;
            for (int r = 0; r < ROWS; r++) begin
                int mag = neg ? ((wv[r] < 0) ? -wv[r] : 0) : ((wv[r] > 0) ? wv[r] : 0);
                s += ((av[r] >> (k*SLICE_W)) & 15) * ((mag >> b) & 1);
            end
            c[b*CODE_W +: CODE_W] = CODE_W'(s);
        end
        return c;
    endfunction

    function automatic logic [WBITS*CODE_W-1:0] all_codes(input int v);
        logic [WBITS*CODE_W-1:0] c;
        for (int b = 0; b < WBITS; b++) c[b*CODE_W +: CODE_W] = CODE_W'(v);
        return c;
    endfunction

    // one full operation driven with given codes per slice
    task automatic run_codes(input logic [ROWS*ACT_W-1:0] act,
                             input logic [WBITS*CODE_W-1:0] p0, n0, p1, n1,
                             input longint exp, input string req);
        start = 1'b1; act_in = act;
        tick();
        start = 1'b0;
        chk(slice_valid && busy && slice_idx == 0, "R2 first slice", slice_idx, 0);
        chk(slice_data == {act[ACT_W +: SLICE_W], act[0 +: SLICE_W]}, "R2 low nibbles",
            slice_data, {act[ACT_W +: SLICE_W], act[0 +: SLICE_W]});
        code_pos = p0; code_neg = n0; code_valid = 1'b1;
        tick();
        chk(slice_valid && slice_idx == 1, "R3 second slice", slice_idx, 1);
        chk(slice_data == {act[ACT_W+SLICE_W +: SLICE_W], act[SLICE_W +: SLICE_W]},
            "R3 high nibbles", slice_data,
            {act[ACT_W+SLICE_W +: SLICE_W], act[SLICE_W +: SLICE_W]});
        code_pos = p1; code_neg = n1;
        tick();
        code_valid = 1'b0; code_pos = '0; code_neg = '0;
        chk(res_valid && !slice_valid, "R7 result due", res_valid, 1);
        chk(longint'(res_data) == exp, req, res_data, exp);
        res_ready = 1'b1;
        tick();
        res_ready = 1'b0;
        chk(!res_valid && !busy, "R7 result taken", res_valid, 0);
    endtask

    task automatic run_dot(input int a0, a1, w0, w1, input string req);
        longint exp = longint'(a0) * w0 + longint'(a1) * w1;
        run_codes({ACT_W'(a1), ACT_W'(a0)},
                  model_codes(a0, a1, w0, w1, 0, 0), model_codes(a0, a1, w0, w1, 0, 1),
                  model_codes(a0, a1, w0, w1, 1, 0), model_codes(a0, a1, w0, w1, 1, 1),
                  exp, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; code_valid = 1'b0; res_ready = 1'b0;
        act_in = '0; code_pos = '0; code_neg = '0;
        tick(); tick();
        chk(!busy && !slice_valid && !res_valid, "R1 reset idle", busy, 0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_columns();
        logic [WBITS*CODE_W-1:0] c3 = '0;
        c3[3*CODE_W +: CODE_W] = CODE_W'(1);
        run_codes('0, c3, '0, '0, '0, 8, "R4 column 3 weight 8");
        run_codes('0, '0, '0, c3, '0, 128, "R5 column 3 upper slice weight 128");
    endtask

    task automatic t_max();
        run_codes('0, all_codes(CMAX), '0, all_codes(CMAX), '0, 32385, "R9 max positive");
        run_codes('0, '0, all_codes(CMAX), '0, all_codes(CMAX), -32385, "R9 max negative");
    endtask

    task automatic t_hold_busy();
        start = 1'b1; act_in = {8'd2, 8'd1};
        tick();
        start = 1'b0;
        tick(); tick();
        chk(slice_valid && slice_idx == 0, "R3 slice held", slice_idx, 0);
        start = 1'b1; act_in = {8'hFF, 8'hFF};
        tick();
        start = 1'b0;
        chk(slice_valid && slice_idx == 0 && slice_data == {4'd2, 4'd1},
            "R8 start while driving", slice_data, {4'd2, 4'd1});
        code_pos = model_codes(1, 2, 3, 3, 0, 0); code_neg = '0; code_valid = 1'b1;
        tick();
        code_pos = model_codes(1, 2, 3, 3, 1, 0);
        tick();
        code_valid = 1'b0; code_pos = '0;
        start = 1'b1;
        tick(); tick();
        start = 1'b0;
        chk(res_valid && !slice_valid && longint'(res_data) == 9, "R8 start while held",
            res_data, 9);
        tick();
        chk(res_valid && longint'(res_data) == 9, "R7 held value", res_data, 9);
        res_ready = 1'b1;
        tick();
        res_ready = 1'b0;
        chk(!busy, "R7 released", busy, 0);
    endtask

    task automatic t_stray();
        code_pos = all_codes(CMAX); code_neg = all_codes(5); code_valid = 1'b1;
        tick(); tick();
        code_valid = 1'b0; code_pos = '0; code_neg = '0;
        chk(!busy && !res_valid && !slice_valid, "R10 stray codes idle", busy, 0);
        run_dot(20, 33, 6, -2, "R10 result after stray codes");
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run_dot(3, 5, 1, 2, "R4 low nibble dot");
        run_dot(8'hA7, 8'h3C, 7, -5, "R5 two slice signed dot");
        run_dot(8'hFF, 8'h01, -15, 3, "R6 negative dot");
        run_dot(0, 0, 9, -9, "R6 zero activations");
        t_columns();
        t_max();
        t_hold_busy();
        t_stray();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(!busy && !res_valid, "R1 reset after use", busy, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule